// File: doc/BRIEF.md
# Parallel Port Controller Core

This block sits on a byte-wide synchronous register bus and drives three 8-bit parallel ports named A, B and C. A two-bit address picks one of the three port registers or the control register. Writes to the control register are decoded into one of two kinds. The first kind defines direction and mode for the two port groups. The second kind sets or clears one bit of port C.

The ports are split into two groups. Group A is port A plus the upper nibble of C. Group B is port B plus the lower nibble of C. Each direction field covers a whole byte or a whole nibble. In the basic mode, an output byte is held in a latch and driven onto the pins with its output enables active. An input byte is read straight from the pins.

The mode fields for the strobed and bidirectional modes are stored and can be read back. The pin behaviour for those modes comes from separate handshake blocks, so this core always behaves as in the basic mode.

Top module: `ppi_core`

## Requirements
- R1: After reset every port is an input, all output latches and pins driven out are 0, all output enables are 0, and a control-register read returns 0x9B.
- R2: A bus access with `cs` high uses `addr` as follows: 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register.
- R3: A control write with bit 7 = 1 sets the directions, where 1 means input. Bit 4 sets port A, bit 3 sets C[7:4], bit 1 sets port B and bit 0 sets C[3:0]. The output enables of each field are high exactly when that field is an output.
- R4: A control write with bit 7 = 1 also stores the group A mode from bits 6:5 and the group B mode from bit 2. A control read returns all stored fields at the bit positions they were written from, with bit 7 read as 1.
- R5: A control write with bit 7 = 1 clears the output latches of ports A, B and C to 0.
- R6: A control write with bit 7 = 0 writes bit 0 into the port C latch bit selected by bits 3:1. No other latch bit changes. The direction and mode settings do not change, and bits 6:4 have no effect.
- R7: A write to a port stores the byte in its output latch, and the latch drives that port's output pins from the next clock edge until the latch is changed again.
- R8: A read of port A or port B while it is an input returns its pin values. While it is an output, the read returns its latch.
- R9: A read of port C returns, for each nibble, the pin values when that nibble is an input and the latch when it is an output.
- R10: Read data appears on `rdata` one clock after the read strobe is sampled and then stays unchanged until the next read.
- R11: Read and write strobes are ignored while `cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_i | input | 8 | Port A pin input |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin input |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin input |
| pc_o | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The ports are driven with distinct, asymmetric pin bytes such as 0x5A, 0xC3 and 0x96. Because these values differ from each other and from the latch contents, a read shows whether data came from the pins or from the latch, and from which port. Three direction setups are used: all inputs, all outputs, and a split of port C's nibbles. The split setup separates a per-nibble direction choice from a per-byte one. Bit set/reset words are sent with the don't-care bits set, and one is aimed at an input bit of C, so that a wrong index or a leak into the settings shows up on the pins or in the readback. Accesses with `cs` low are followed by a check of the pins and of `rdata`.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    localparam int BUS_W  = 8;
    localparam int N_PORT = 3;

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } sel_e;

    // field order matches control word bits 6..0
    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       a_in;
        logic       cu_in;
        logic       grp_b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{grp_a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                   grp_b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
    import ppi_pkg::*;
#(
    parameter  int DW = BUS_W,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic          clr_latch,
    output logic          bit_en,
    output logic [IW-1:0] bit_idx,
    output logic          bit_val
);

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;
    logic   is_mode_word;

    always_comb begin
        st_d         = st_q;
        is_mode_word = wdata[DW-1];
        clr_latch    = wr_ctrl && is_mode_word;
        bit_en       = wr_ctrl && !is_mode_word;
        bit_idx      = wdata[IW:1];
        bit_val      = wdata[0];
        if (clr_latch) begin
            st_d.cfg.grp_a_mode = wdata[6:5];
            st_d.cfg.a_in       = wdata[4];
            st_d.cfg.cu_in      = wdata[3];
            st_d.cfg.grp_b_mode = wdata[2];
            st_d.cfg.b_in       = wdata[1];
            st_d.cfg.cl_in      = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET};
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    AST_BSR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[DW-1]) |=> $stable(cfg)); // R6

    AST_MODE_SETS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[DW-1]) |=> (cfg.a_in == $past(wdata[4]) && cfg.b_in == $past(wdata[1]))); // R3

endmodule

// File: rtl/ppi_port_reg.sv
module ppi_port_reg #(
    parameter  int W          = 8,
    parameter  bit HAS_BIT_OP = 1'b0,
    localparam int IW         = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic          bit_en,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    input  logic [W-1:0]  dir_in,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  rd_val
);

    typedef struct packed {
        logic [W-1:0] latch;
    } state_t;

    state_t       st_d, st_q;
    logic         bit_go;
    logic [W-1:0] bit_upd;

    assign bit_go = bit_en && HAS_BIT_OP;

    always_comb begin
        bit_upd          = st_q.latch;
        bit_upd[bit_idx] = bit_val;
    end

    always_comb begin
        st_d = st_q;
        if (clr)         st_d.latch = '0;
        else if (wr_en)  st_d.latch = wdata;
        else if (bit_go) st_d.latch = bit_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            assign pin_oe[gi] = ~dir_in[gi];
            assign rd_val[gi] = dir_in[gi] ? pin_in[gi] : st_q.latch[gi];
        end
    endgenerate

    assign pin_out = st_q.latch;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pin_out == '0)); // R5

    AST_WRITE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (pin_out == $past(wdata))); // R7

    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !wr_en) |=> ($countones(pin_out ^ $past(pin_out)) <= 1)); // R6

endmodule

// File: rtl/ppi_rd_mux.sv
module ppi_rd_mux
    import ppi_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_fire,
    input  sel_e                     sel,
    input  logic [N_PORT-1:0][DW-1:0] port_val,
    input  cfg_t                     cfg,
    output logic [DW-1:0]            rdata
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } state_t;

    state_t        st_d, st_q;
    logic [DW-1:0] ctrl_view;

    assign ctrl_view = {1'b1, cfg};

    always_comb begin
        st_d = st_q;
        if (rd_fire) begin
            unique case (sel)
                SEL_A:    st_d.rdata = port_val[0];
                SEL_B:    st_d.rdata = port_val[1];
                SEL_C:    st_d.rdata = port_val[2];
                default:  st_d.rdata = ctrl_view;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    AST_CTRL_READ_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && sel == SEL_CTRL) |=> rdata[DW-1]); // R4

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rdata)); // R10

endmodule

// File: rtl/ppi_core.sv
module ppi_core
    import ppi_pkg::*;
#(
    parameter  int DW   = BUS_W,
    localparam int HALF = DW / 2,
    localparam int IW   = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_i,
    output logic [DW-1:0] pa_o,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_i,
    output logic [DW-1:0] pb_o,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_i,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] pc_oe
);

    sel_e          sel;
    logic          wr_fire, rd_fire;
    cfg_t          cfg;
    logic          clr_latch, bit_en, bit_val;
    logic [IW-1:0] bit_idx;

    logic [N_PORT-1:0][DW-1:0] dir_mask, pin_in, pin_out, pin_oe, port_val;

    assign sel     = sel_e'(addr);
    assign wr_fire = cs && wr;
    assign rd_fire = cs && rd;

    ppi_ctrl_reg #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_fire && sel == SEL_CTRL),
        .wdata     (wdata),
        .cfg       (cfg),
        .clr_latch (clr_latch),
        .bit_en    (bit_en),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val)
    );

    assign dir_mask[0] = {DW{cfg.a_in}};
    assign dir_mask[1] = {DW{cfg.b_in}};
    assign dir_mask[2] = {{HALF{cfg.cu_in}}, {(DW-HALF){cfg.cl_in}}};
    assign pin_in[0]   = pa_i;
    assign pin_in[1]   = pb_i;
    assign pin_in[2]   = pc_i;

    genvar gp;
    generate
        for (gp = 0; gp < N_PORT; gp++) begin : g_port
            ppi_port_reg #(.W(DW), .HAS_BIT_OP(gp == 2)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr_latch),
                .wr_en   (wr_fire && addr == gp[1:0]),
                .wdata   (wdata),
                .bit_en  (bit_en),
                .bit_idx (bit_idx),
                .bit_val (bit_val),
                .dir_in  (dir_mask[gp]),
                .pin_in  (pin_in[gp]),
                .pin_out (pin_out[gp]),
                .pin_oe  (pin_oe[gp]),
                .rd_val  (port_val[gp])
            );
        end
    endgenerate

    ppi_rd_mux #(.DW(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .sel      (sel),
        .port_val (port_val),
        .cfg      (cfg),
        .rdata    (rdata)
    );

    assign pa_o  = pin_out[0];
    assign pb_o  = pin_out[1];
    assign pc_o  = pin_out[2];
    assign pa_oe = pin_oe[0];
    assign pb_oe = pin_oe[1];
    assign pc_oe = pin_oe[2];

    AST_IDLE_BUS_HOLDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pc_oe))); // R11

endmodule

// File: tb/ppi_core_tb.sv
module ppi_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
    logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    logic  rd_pend = 1'b0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppi_core dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
        .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
        .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: a read accepted at a clock edge is compared at the next falling edge
    always @(posedge clk) rd_pend <= cs && rd && rst_n;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R10: read data with no expected item, actual %h expected none", rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, rdata, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 pa_o", pa_o, 8'h00);
        check("R1 pc_o", pc_o, 8'h00);
        bus_read(2'b11, 8'h9B, "R1 control readback after reset");

        // R2 R8 R9 all inputs: reads come from the pins
        pa_i = 8'h5A; pb_i = 8'hC3; pc_i = 8'h96;
        bus_read(2'b00, 8'h5A, "R2 R8 port A pins");
        bus_read(2'b01, 8'hC3, "R2 R8 port B pins");
        bus_read(2'b10, 8'h96, "R2 R9 port C pins");

        // R3 all outputs
        bus_write(2'b11, 8'h80);
        check("R3 pa_oe all out", pa_oe, 8'hFF);
        check("R3 pb_oe all out", pb_oe, 8'hFF);
        check("R3 pc_oe all out", pc_oe, 8'hFF);
        bus_read(2'b11, 8'h80, "R4 control readback 0x80");

        // R7 latched outputs
        bus_write(2'b00, 8'h3C);
        bus_write(2'b01, 8'hA5);
        bus_write(2'b10, 8'h7E);
        check("R7 pa_o", pa_o, 8'h3C);
        check("R7 pb_o", pb_o, 8'hA5);
        check("R7 pc_o", pc_o, 8'h7E);
        repeat (3) @(negedge clk);
        check("R7 pa_o held", pa_o, 8'h3C);
        bus_read(2'b00, 8'h3C, "R8 port A output reads latch");
        bus_read(2'b01, 8'hA5, "R8 port B output reads latch");
        bus_read(2'b10, 8'h7E, "R9 port C output reads latch");

        // R11 strobes ignored with cs low; R10 rdata holds
        bus_write(2'b00, 8'hFF, 1'b0);
        check("R11 pa_o unchanged by deselected write", pa_o, 8'h3C);
        @(negedge clk);
        addr = 2'b11; rd = 1'b1; cs = 1'b0;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        check("R10 R11 rdata holds after deselected read", rdata, 8'h7E);

        // R6 bit set/reset on port C
        bus_write(2'b11, 8'h0F);
        check("R6 set bit 7", pc_o, 8'hFE);
        bus_write(2'b11, 8'h74);
        check("R6 clear bit 2, bits 6:4 ignored", pc_o, 8'hFA);
        check("R6 port A untouched", pa_o, 8'h3C);
        bus_read(2'b11, 8'h80, "R6 settings unchanged by bit word");

        // R4 R5 R3 mode word with upper C input and modes set
        bus_write(2'b11, 8'hEC);
        check("R5 pa_o cleared", pa_o, 8'h00);
        check("R5 pb_o cleared", pb_o, 8'h00);
        check("R5 pc_o cleared", pc_o, 8'h00);
        check("R3 pc_oe split", pc_oe, 8'h0F);
        check("R3 pa_oe out", pa_oe, 8'hFF);
        bus_read(2'b11, 8'hEC, "R4 control readback 0xEC");
        bus_read(2'b10, 8'h90, "R9 port C split read");
        bus_write(2'b11, 8'h03);
        bus_read(2'b10, 8'h92, "R9 R6 lower nibble latch bit 1");
        pc_i = 8'h16;
        bus_write(2'b11, 8'h0F);
        check("R6 input bit latch set", pc_o, 8'h82);
        bus_read(2'b10, 8'h12, "R9 input nibble shows pins");

        // R3 R8 port A and B inputs, C outputs
        bus_write(2'b11, 8'h92);
        check("R3 pa_oe in", pa_oe, 8'h00);
        check("R3 pb_oe in", pb_oe, 8'h00);
        check("R3 pc_oe out", pc_oe, 8'hFF);
        bus_write(2'b00, 8'h11);
        bus_read(2'b00, 8'h5A, "R8 input port A ignores latch");
        bus_read(2'b11, 8'h92, "R4 control readback 0x92");

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", 8'(sb_q.size()), 8'h00);
        done = 1'b1;
        finish_run();
    end

endmodule